// File: doc/BRIEF.md
# Five-Repeat Majority Voter with Early Decision

On a control channel, every data word is sent five times in each frame. This block takes those five received copies and forms one word from them. Each bit of that word is the majority vote of the same bit across the copies. The recovered word arrives with a valid strobe. A frame-start marker begins each new group of repeats.

In early mode the block checks the first three copies. If they match exactly, that word is final, because no later copies can outvote it. The block then outputs it at once and drives an active-low early-decision pin low. The controller can use that pin to switch the receiver off for the rest of the frame. A two-bit lead setting decides how many bit periods the pin leads the next dotting sequence. The setting is counted on a bit-rate enable pulse, so a larger setting makes the pin fall sooner after the third copy.

Top module: `maj5_early_voter`

## Requirements
- R1: With early_mode_i low, the voted word appears on voted_o, and voted_valid_o pulses for one cycle, in the cycle after the clock edge that samples the fifth accepted word. Bit b of voted_o is 1 exactly when at least three of the five copies have bit b set.
- R2: With early_mode_i low, the block waits for all five copies even when the first three are identical, and early_n_o stays high for the whole frame.
- R3: With early_mode_i high and the first three copies bit-for-bit identical, voted_o takes that word and voted_valid_o pulses in the cycle after the edge that samples the third copy. Copies four and five then produce no further pulse.
- R4: With early_mode_i high and the first three copies not identical, the frame is voted over five copies as in R1, and early_n_o stays high.
- R5: After an early decision, with lead_sel_i = k sampled together with the third copy: for k = 3, early_n_o falls at the same edge as the voted_valid_o pulse. Otherwise it falls at the edge that samples the (3 - k)-th bit_en_i pulse after the third copy.
- R6: A frame_start_i pulse restarts the repeat count and drives early_n_o high after the edge that samples it. A word that is valid in the same cycle is taken as copy one of the new frame.
- R7: Only five words are accepted after a frame start. Any further words change neither voted_o nor voted_valid_o until the next frame_start_i.
- R8: During and right after reset, early_n_o is high, voted_valid_o is low and voted_o is all zeros.
- R9: Once early_n_o is low, it stays low until a frame_start_i is sampled, whatever the word and bit-enable inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start of a new frame of repeats |
| word_valid_i | input | 1 | word_i holds a received copy |
| word_i | input | WORD_W (40) | Received word copy |
| early_mode_i | input | 1 | 1: early decision on three matching copies; 0: always five copies |
| lead_sel_i | input | LEAD_W (2) | Lead of the early indication, in bit periods |
| bit_en_i | input | 1 | Bit-rate enable, one pulse per bit period |
| voted_o | output | WORD_W (40) | Majority-voted word, held until the next decision |
| voted_valid_o | output | 1 | One-cycle pulse when voted_o is updated |
| early_n_o | output | 1 | Low when the receiver may be switched off |

## Verification
The hardest case to reach is a frame that only just fails the early check: the first three copies differ by a single bit, or copies four and five would have outvoted the first three in five-copy mode. To reach it, the random stimulus builds each frame from one base word. About half the frames copy that word exactly into the first three slots. The rest flip one or two random bits in chosen copies. Directed frames cover every lead setting with sparse bit-enable pulses, a frame start that lands in the middle of a lead countdown, and words arriving past the fifth copy.

// File: rtl/maj5_pkg.sv
package maj5_pkg;
  localparam int unsigned NUM_REP    = 5;
  localparam int unsigned EARLY_REP  = 3;
  localparam int unsigned HIST_DEPTH = NUM_REP - 1;
  localparam int unsigned IDX_W      = $clog2(NUM_REP + 1);
  typedef logic [IDX_W-1:0] rep_idx_t;
endpackage

// File: rtl/maj5_rep_store.sv
module maj5_rep_store
  import maj5_pkg::*;
#(
  parameter int unsigned WORD_W = 40
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  frame_start_i,
  input  logic                                  word_valid_i,
  input  logic [WORD_W-1:0]                     word_i,
  output rep_idx_t                              idx_o,
  output logic                                  accept_o,
  output logic [HIST_DEPTH-1:0][WORD_W-1:0]     hist_o
);
  rep_idx_t cnt_q;

  // a frame start re-bases the word in the same cycle to copy one
  assign idx_o    = frame_start_i ? '0 : cnt_q;
  assign accept_o = word_valid_i && (idx_o < rep_idx_t'(NUM_REP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (accept_o)      cnt_q <= idx_o + 1'b1;
    else if (frame_start_i) cnt_q <= '0;
  end

  for (genvar s = 0; s < HIST_DEPTH; s++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (accept_o && (idx_o == rep_idx_t'(s))) slot_q <= word_i;
    end
    assign hist_o[s] = slot_q;
  end

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= rep_idx_t'(NUM_REP));
  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !word_valid_i) |=> (cnt_q == '0));
endmodule

// File: rtl/maj5_bit_vote.sv
module maj5_bit_vote #(
  parameter int unsigned WORD_W   = 40,
  parameter int unsigned N_COPIES = 5
) (
  input  logic [N_COPIES-1:0][WORD_W-1:0] copies_i,
  output logic [WORD_W-1:0]               vote_o
);
  localparam int unsigned SUM_W  = $clog2(N_COPIES + 1);
  localparam int unsigned THRESH = N_COPIES / 2 + 1;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    logic [SUM_W-1:0] ones;
    always_comb begin
      ones = '0;
      for (int c = 0; c < N_COPIES; c++) ones = ones + SUM_W'(copies_i[c][b]);
    end
    assign vote_o[b] = (ones >= SUM_W'(THRESH));
  end
endmodule

// File: rtl/maj5_lead_timer.sv
module maj5_lead_timer #(
  parameter int unsigned LEAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [LEAD_W-1:0] lead_sel_i,
  input  logic              bit_en_i,
  output logic              early_n_o
);
  localparam int unsigned LEAD_MAX = (1 << LEAD_W) - 1;

  logic [LEAD_W-1:0] wait_q, wait_init;
  logic              armed_q, early_n_q;

  // larger lead means fewer bit periods of wait
  assign wait_init = LEAD_W'(LEAD_MAX) - lead_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q    <= '0;
      armed_q   <= 1'b0;
      early_n_q <= 1'b1;
    end else if (clear_i) begin
      armed_q   <= 1'b0;
      early_n_q <= 1'b1;
    end else if (load_i) begin
      if (wait_init == '0) begin
        early_n_q <= 1'b0;
      end else begin
        armed_q <= 1'b1;
        wait_q  <= wait_init;
      end
    end else if (armed_q && bit_en_i) begin
      if (wait_q == LEAD_W'(1)) begin
        early_n_q <= 1'b0;
        armed_q   <= 1'b0;
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign early_n_o = early_n_q;

  a_r6_clear_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> early_n_o);
  a_r9_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!early_n_o && !clear_i) |=> !early_n_o);
  a_r5_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(early_n_o) |-> ($past(load_i) || $past(bit_en_i)));
endmodule

// File: rtl/maj5_early_voter.sv
module maj5_early_voter
  import maj5_pkg::*;
#(
  parameter int unsigned WORD_W = 40,
  parameter int unsigned LEAD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              early_mode_i,
  input  logic [LEAD_W-1:0] lead_sel_i,
  input  logic              bit_en_i,
  output logic [WORD_W-1:0] voted_o,
  output logic              voted_valid_o,
  output logic              early_n_o
);
  rep_idx_t                              idx;
  logic                                  accept;
  logic [HIST_DEPTH-1:0][WORD_W-1:0]     hist;
  logic [NUM_REP-1:0][WORD_W-1:0]        copies;
  logic [WORD_W-1:0]                     vote;
  logic                                  agree, early_hit, final_hit;
  logic                                  decided_q, valid_q;
  logic [WORD_W-1:0]                     voted_q;

  maj5_rep_store #(.WORD_W(WORD_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .idx_o        (idx),
    .accept_o     (accept),
    .hist_o       (hist)
  );

  assign copies = {word_i, hist};

  maj5_bit_vote #(.WORD_W(WORD_W), .N_COPIES(NUM_REP)) u_vote (
    .copies_i(copies),
    .vote_o  (vote)
  );

  always_comb begin
    agree = 1'b1;
    for (int k = 0; k < EARLY_REP - 1; k++) agree = agree && (hist[k] == word_i);
  end

  assign early_hit = accept && (idx == rep_idx_t'(EARLY_REP - 1)) && early_mode_i && agree;
  assign final_hit = accept && (idx == rep_idx_t'(NUM_REP - 1)) && !decided_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decided_q <= 1'b0;
      valid_q   <= 1'b0;
      voted_q   <= '0;
    end else begin
      decided_q <= early_hit || (decided_q && !frame_start_i);
      valid_q   <= early_hit || final_hit;
      if (early_hit)      voted_q <= word_i;
      else if (final_hit) voted_q <= vote;
    end
  end

  assign voted_o       = voted_q;
  assign voted_valid_o = valid_q;

  maj5_lead_timer #(.LEAD_W(LEAD_W)) u_lead (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (frame_start_i),
    .load_i    (early_hit),
    .lead_sel_i(lead_sel_i),
    .bit_en_i  (bit_en_i),
    .early_n_o (early_n_o)
  );

  // one decision per frame
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= !frame_start_i && (seen_q || voted_valid_o);
  end

  a_r7_one_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    voted_valid_o |-> !seen_q);
  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    voted_valid_o |=> !voted_valid_o);
  a_r5_early_after_vote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(early_n_o) |-> (seen_q || voted_valid_o));
  a_r2_no_early_mode0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !early_mode_i && idx == rep_idx_t'(EARLY_REP - 1) && early_n_o) |=> early_n_o);
endmodule

// File: tb/maj5_early_voter_tb.sv
module maj5_early_voter_tb;
  localparam int W = 40;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         frame_start_i = 1'b0, word_valid_i = 1'b0, bit_en_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         early_mode_i = 1'b0;
  logic [1:0]   lead_sel_i = 2'd0;
  logic [W-1:0] voted_o;
  logic         voted_valid_o, early_n_o;

  always #2.5 clk = ~clk;

  maj5_early_voter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .early_mode_i(early_mode_i),
    .lead_sel_i(lead_sel_i), .bit_en_i(bit_en_i), .voted_o(voted_o),
    .voted_valid_o(voted_valid_o), .early_n_o(early_n_o)
  );

  int errors = 0, checks = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  int           m_cnt, m_wait;
  logic [W-1:0] m_hist [5];
  logic [W-1:0] m_word;
  bit           m_done, m_armed, m_early, m_vld;
  logic [W-1:0] fw [8];

  function automatic logic [W-1:0] maj5(input logic [W-1:0] a, b, c, d, e);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i]) + int'(d[i]) + int'(e[i])) >= 3;
    return r;
  endfunction

  function automatic logic [W-1:0] rword();
    return W'({$urandom(), $urandom()});
  endfunction

  task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_wait = 0; m_done = 0; m_armed = 0; m_early = 1; m_vld = 0; m_word = '0;
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit fs, input bit wv, input logic [W-1:0] w, input bit be);
    frame_start_i = fs; word_valid_i = wv; word_i = w; bit_en_i = be;
    @(posedge clk);
    m_vld = 0;
    if (fs) begin
      m_cnt = 0; m_early = 1; m_armed = 0; m_done = 0;
    end else if (m_armed && be) begin
      if (m_wait == 1) begin m_early = 0; m_armed = 0; end
      else m_wait--;
    end
    if (wv && m_cnt < 5) begin
      m_hist[m_cnt] = w;
      if (m_cnt == 2 && early_mode_i && m_hist[0] == m_hist[1] && m_hist[1] == w) begin
        m_vld = 1; m_word = w; m_done = 1;
        if (lead_sel_i == 2'd3) m_early = 0;
        else begin m_armed = 1; m_wait = 3 - int'(lead_sel_i); end
      end else if (m_cnt == 4 && !m_done) begin
        m_vld = 1; m_word = maj5(m_hist[0], m_hist[1], m_hist[2], m_hist[3], w);
      end
      m_cnt++;
    end
    @(negedge clk);
    chk(tag, "voted_valid_o", 64'(voted_valid_o), 64'(m_vld));
    chk(tag, "voted_o", 64'(voted_o), 64'(m_word));
    chk(tag, "early_n_o", 64'(early_n_o), 64'(m_early));
    frame_start_i = 0; word_valid_i = 0; bit_en_i = 0;
  endtask

  // sends n words from fw, frame start on the first; gap cycles between words
  task automatic send(input int n, input int gap, input int be_pct);
    for (int i = 0; i < n; i++) begin
      step(i == 0, 1'b1, fw[i], ($urandom % 100) < be_pct);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, rword(), ($urandom % 100) < be_pct);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "early_n_o", 64'(early_n_o), 64'd1);
    chk("R8", "voted_valid_o", 64'(voted_valid_o), 64'd0);
    chk("R8", "voted_o", 64'(voted_o), 64'd0);
    rst_ni = 1;
    @(negedge clk);
    chk("R8", "voted_o after release", 64'(voted_o), 64'd0);

    // R1: five-copy vote, known pattern
    tag = "R1"; early_mode_i = 0;
    fw[0] = 40'hFF00FF00FF; fw[1] = 40'hF0F0F0F0F0; fw[2] = 40'hCCCCCCCCCC;
    fw[3] = 40'hAAAAAAAAAA; fw[4] = 40'h0F0F0F0F0F;
    send(5, 1, 50);
    step(0, 0, '0, 0);

    // R2: mode 0 ignores early agreement
    tag = "R2"; early_mode_i = 0; lead_sel_i = 3;
    fw[0] = 40'h123456789A; fw[1] = fw[0]; fw[2] = fw[0]; fw[3] = ~fw[0]; fw[4] = ~fw[0];
    send(5, 0, 100);
    repeat (6) step(0, 0, '0, 1);

    // R3 and R5: early decision at each lead setting, sparse bit enables
    for (int k = 0; k < 4; k++) begin
      tag = (k == 3) ? "R3" : "R5"; early_mode_i = 1; lead_sel_i = 2'(k);
      fw[0] = rword(); fw[1] = fw[0]; fw[2] = fw[0]; fw[3] = rword(); fw[4] = rword();
      send(3, 0, 0);
      for (int c = 0; c < 12; c++) step(0, 0, '0, (c % 3) == 2);
      tag = "R9";
      step(0, 1, fw[3], 1); step(0, 1, fw[4], 1);
      repeat (4) step(0, 0, rword(), 1);
    end

    // R4: first three differ in one bit
    tag = "R4"; early_mode_i = 1; lead_sel_i = 3;
    fw[0] = rword(); fw[1] = fw[0]; fw[2] = fw[0] ^ 40'h1; fw[3] = rword(); fw[4] = rword();
    send(5, 1, 100);
    step(0, 0, '0, 1);

    // R6: frame start mid-countdown and mid-frame, word with start is copy one
    tag = "R6"; early_mode_i = 1; lead_sel_i = 0;
    fw[0] = rword(); fw[1] = fw[0]; fw[2] = fw[0];
    send(3, 0, 0);
    step(0, 0, '0, 1);
    step(1, 0, '0, 1);
    repeat (5) step(0, 0, '0, 1);
    fw[0] = rword(); fw[1] = rword(); fw[2] = rword(); fw[3] = rword(); fw[4] = rword();
    send(2, 0, 0);
    send(5, 0, 30);

    // R7: words beyond the fifth
    tag = "R7"; early_mode_i = 0;
    for (int i = 0; i < 8; i++) fw[i] = rword();
    send(8, 0, 50);
    step(1, 0, '0, 0);

    // random frames
    for (int f = 0; f < 400; f++) begin
      tag = "R1/R3/R4/R5";
      early_mode_i = $urandom % 2; lead_sel_i = 2'($urandom % 4);
      fw[0] = rword();
      for (int i = 1; i < 8; i++) fw[i] = fw[0];
      if ($urandom % 2) begin
        for (int i = 0; i < 5; i++)
          if ($urandom % 3 == 0) fw[i] = fw[i] ^ (W'(1) << ($urandom % W)) ^ (W'(1) << ($urandom % W));
      end else begin
        fw[3] = rword(); fw[4] = rword();
      end
      send(3 + $urandom % 5, $urandom % 3, 40);
      repeat ($urandom % 6) step(0, 0, rword(), ($urandom % 2) == 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule